// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Controller

This block is the control and status unit of a compact 32-bit RISC-V style core that only ever runs at machine privilege. It owns the registers that govern trap entry and exit: the global status bits, the enable and pending masks, the trap vector, the saved return address, the cause code, and a free-running cycle count. It also owns a 32-bit machine timer with a compare register, and the pending logic for a parameterised set of local interrupt lines. The pipeline sends it CSR requests (read, write, set bits, clear bits), synchronous exception reports and `mret`. It answers with a registered CSR read value, a redirect strobe with its target PC, and a flag that marks the redirect as a trap entry.

Every decision the block makes is registered. A CSR request, exception or `mret` presented in one cycle shows its result at the outputs after the next rising edge. This gives the pipeline the two-cycle completion it expects for CSR instructions.

Top module: `mtrap_unit`

## Requirements
- R1: CSR ops use `csr_op_i` as follows: 0 = read only, 1 = write, 2 = set bits, 3 = clear bits. `csr_rdata_o` shows the register's value from before the operation, one cycle after the request. The addresses are: status 0x300, enable 0x304, vector 0x305, return PC 0x341, cause 0x342, pending 0x344, cycle 0xB00, timer 0x7C0, timer compare 0x7C1. The return PC always reads with bits 1:0 equal to zero. The vector stores all 32 bits.
- R2: The cycle counter increments on every clock. A write loads the written value, and counting continues from that value on the following edge.
- R3: The 32-bit timer increments on every clock with the default prescale of 1. A write loads it. The timer-pending bit (bit 7 of the pending register) reads 1 exactly when timer >= compare. The compare register resets to 0xFFFFFFFF.
- R4: The enable register has writable bits 7 (timer), 11 (external) and 16..23 (local lines 0..7); all other bits read zero. The pending register shows bit 7 = timer pending, bit 11 = `ext_irq_i` and bit 16+n = `lirq_i[n]`. Writes to the pending register have no effect.
- R5: On any trap, the block registers the following at the same edge. The return PC takes the faulting PC, or `next_pc_i` for an interrupt. The previous-enable bit (status bit 7) takes the global enable (status bit 3), and the global enable is cleared. In the next cycle, `trap_o` and `redirect_o` are 1 and `redirect_pc_o` is the vector with bits 1:0 forced to zero.
- R6: Exception kinds on `exc_kind_i` map to cause codes as follows, with cause bit 31 clear: 0 illegal opcode → 2, 1 fetch misaligned → 0, 2 load misaligned → 4, 3 store misaligned → 6, 4 ebreak → 3, 5 ecall → 11.
- R7: A CSR request to an address not listed in R1 raises an illegal-instruction trap with cause 2 and return PC `cur_pc_i`. Its read data is 0.
- R8: An interrupt is taken only when the global enable is 1 and some source has both its enable and pending bits set. It is never taken in a cycle that carries a CSR request. Its cause is 0x80000000 plus the source's bit position from R4.
- R9: Among interrupts, the local lines win first (lowest index first), then the timer, then the external line. An exception reported in the same cycle as a takeable interrupt wins.
- R10: On `mret`, the global enable takes the previous-enable bit and the previous-enable bit is set to 1. In the next cycle, `redirect_o` is 1, `trap_o` is 0, and `redirect_pc_o` equals the return PC.
- R11: After reset, the following hold. Status reads 0x1800 (machine mode in the previous-mode field, both enables clear). Enable, return PC, cause and cycle count are zero. The vector holds `RESET_TVEC`. `trap_o` and `redirect_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_req_i | input | 1 | CSR access request this cycle |
| csr_op_i | input | 2 | CSR operation (read, write, set, clear) |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Operand for write, set or clear |
| csr_rdata_o | output | 32 | Prior value of the addressed CSR, one cycle after the request |
| cur_pc_i | input | 32 | PC of the instruction presented this cycle |
| next_pc_i | input | 32 | PC the pipeline would resume at if interrupted now |
| exc_valid_i | input | 1 | Synchronous exception reported this cycle |
| exc_kind_i | input | 3 | Exception kind (see R6) |
| mret_i | input | 1 | Return-from-trap request |
| ext_irq_i | input | 1 | External interrupt level |
| lirq_i | input | LOCAL_IRQS | Local interrupt levels |
| redirect_o | output | 1 | Fetch must restart at `redirect_pc_o` |
| redirect_pc_o | output | 32 | Redirect target |
| trap_o | output | 1 | The redirect is a trap entry |

## Verification
Damage to the saved status bits goes unseen until the next trap or `mret`. The bench therefore reads the status register right after every entry and return, and a lost enable bit appears there within two cycles. A fault in interrupt selection shows up as a wrong cause code, or as a trap that arrives one cycle early or late. For this reason, every interrupt test checks `trap_o` in the exact cycle after the enabling event and then reads the cause. A broken counter or compare shows up as an off-by-one in the timer or cycle readback, or as a pending bit set on the wrong side of the compare value.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

   typedef enum logic [1:0] {
      CSR_RD  = 2'd0,
      CSR_WR  = 2'd1,
      CSR_SET = 2'd2,
      CSR_CLR = 2'd3
   } csr_op_e;

   typedef enum logic [2:0] {
      EX_ILLEGAL   = 3'd0,
      EX_FETCH_MIS = 3'd1,
      EX_LOAD_MIS  = 3'd2,
      EX_STORE_MIS = 3'd3,
      EX_BREAK     = 3'd4,
      EX_ECALL     = 3'd5
   } exc_kind_e;

   localparam logic [11:0] A_STATUS = 12'h300;
   localparam logic [11:0] A_ENABLE = 12'h304;
   localparam logic [11:0] A_VECTOR = 12'h305;
   localparam logic [11:0] A_RETPC  = 12'h341;
   localparam logic [11:0] A_CAUSE  = 12'h342;
   localparam logic [11:0] A_PEND   = 12'h344;
   localparam logic [11:0] A_CYCLE  = 12'hB00;
   localparam logic [11:0] A_TIMER  = 12'h7C0;
   localparam logic [11:0] A_TCMP   = 12'h7C1;

   localparam int BIT_GIE    = 3;
   localparam int BIT_PGIE   = 7;
   localparam int BIT_TMR    = 7;
   localparam int BIT_EXT    = 11;
   localparam int LOC_BASE   = 16;
   localparam int LOC_MAX    = 16;
   localparam logic [31:0] MODE_BITS = 32'h0000_1800;

   // cause code for a synchronous exception kind
   function automatic logic [4:0] kind_to_cause(input logic [2:0] kind);
      case (kind)
         EX_FETCH_MIS: return 5'd0;
         EX_LOAD_MIS:  return 5'd4;
         EX_STORE_MIS: return 5'd6;
         EX_BREAK:     return 5'd3;
         EX_ECALL:     return 5'd11;
         default:      return 5'd2;
      endcase
   endfunction

endpackage

// File: rtl/mtrap_csr_alu.sv
module mtrap_csr_alu
   import mtrap_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [1:0]   op_i,
   input  logic [W-1:0] old_i,
   input  logic [W-1:0] arg_i,
   output logic [W-1:0] new_o
);
   always_comb begin
      case (op_i)
         CSR_WR:  new_o = arg_i;
         CSR_SET: new_o = old_i | arg_i;
         CSR_CLR: new_o = old_i & ~arg_i;
         default: new_o = old_i;
      endcase
   end
endmodule

// File: rtl/mtrap_counters.sv
module mtrap_counters
   import mtrap_pkg::*;
#(
   parameter int W        = 32,
   parameter int PRESCALE = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_cyc_i,
   input  logic         wr_time_i,
   input  logic         wr_cmp_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] cycle_o,
   output logic [W-1:0] time_o,
   output logic [W-1:0] cmp_o,
   output logic         tmr_pend_o
);
   logic         tick;
   logic [W-1:0] cyc_q, tim_q, cmp_q;

   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("mtrap_counters: PRESCALE must be at least 1");
      end
      if (PRESCALE == 1) begin : g_tick_every
         assign tick = 1'b1;
      end else begin : g_tick_div
         localparam int CW = $clog2(PRESCALE);
         localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
         logic [CW-1:0] div_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)           div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                   div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cyc_q <= '0;
         tim_q <= '0;
         cmp_q <= '1;
      end else begin
         cyc_q <= wr_cyc_i ? wdata_i : cyc_q + 1'b1;
         if (wr_time_i)  tim_q <= wdata_i;
         else if (tick)  tim_q <= tim_q + 1'b1;
         if (wr_cmp_i)   cmp_q <= wdata_i;
      end
   end

   assign cycle_o    = cyc_q;
   assign time_o     = tim_q;
   assign cmp_o      = cmp_q;
   assign tmr_pend_o = (tim_q >= cmp_q);
endmodule

// File: rtl/mtrap_irq_pick.sv
module mtrap_irq_pick
   import mtrap_pkg::*;
#(
   parameter int NLOC = 8
) (
   input  logic            glb_en_i,
   input  logic [NLOC-1:0] loc_pend_i,
   input  logic [NLOC-1:0] loc_en_i,
   input  logic            tmr_pend_i,
   input  logic            tmr_en_i,
   input  logic            ext_pend_i,
   input  logic            ext_en_i,
   output logic            take_o,
   output logic [4:0]      code_o
);
   logic [NLOC-1:0] live;
   logic            any;

   assign live = loc_pend_i & loc_en_i;

   // later assignments override earlier ones: lowest priority first
   always_comb begin
      any    = 1'b0;
      code_o = '0;
      if (ext_pend_i && ext_en_i) begin
         any    = 1'b1;
         code_o = 5'(BIT_EXT);
      end
      if (tmr_pend_i && tmr_en_i) begin
         any    = 1'b1;
         code_o = 5'(BIT_TMR);
      end
      for (int i = NLOC - 1; i >= 0; i--) begin
         if (live[i]) begin
            any    = 1'b1;
            code_o = 5'(LOC_BASE + i);
         end
      end
   end

   assign take_o = any && glb_en_i;
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
   import mtrap_pkg::*;
#(
   parameter int          LOCAL_IRQS     = 8,
   parameter int          TIMER_PRESCALE = 1,
   parameter logic [31:0] RESET_TVEC     = 32'h0000_0000
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  csr_req_i,
   input  logic [1:0]            csr_op_i,
   input  logic [11:0]           csr_addr_i,
   input  logic [31:0]           csr_wdata_i,
   output logic [31:0]           csr_rdata_o,
   input  logic [31:0]           cur_pc_i,
   input  logic [31:0]           next_pc_i,
   input  logic                  exc_valid_i,
   input  logic [2:0]            exc_kind_i,
   input  logic                  mret_i,
   input  logic                  ext_irq_i,
   input  logic [LOCAL_IRQS-1:0] lirq_i,
   output logic                  redirect_o,
   output logic [31:0]           redirect_pc_o,
   output logic                  trap_o
);
   localparam int XW      = 32;
   localparam int LOC_TOP = LOC_BASE + LOCAL_IRQS - 1;

   generate
      if (LOCAL_IRQS < 1 || LOCAL_IRQS > LOC_MAX) begin : g_bad_lirq
         $error("mtrap_unit: LOCAL_IRQS must lie in 1..16");
      end
   endgenerate

   // architectural state
   logic                  gie_q, pgie_q;
   logic                  en_tmr_q, en_ext_q;
   logic [LOCAL_IRQS-1:0] en_loc_q;
   logic [XW-1:0]         vec_q, cause_q;
   logic [XW-1:3-1]       retpc_q;
   logic [XW-1:0]         retpc_full;

   logic [XW-1:0] cyc_v, tim_v, cmp_v;
   logic          tmr_pend;

   // CSR access path
   logic [XW-1:0] rd_val, wr_val;
   logic          hit, csr_go;
   logic          wr_cyc, wr_tim, wr_cmp;

   // trap decision
   logic          irq_take;
   logic [4:0]    irq_code;
   logic          ill_csr, sync_trap, irq_go, trap_go, ret_go;
   logic [XW-1:0] trap_cause, trap_pc;

   assign retpc_full = {retpc_q, 2'b00};

   always_comb begin
      rd_val = '0;
      hit    = 1'b1;
      case (csr_addr_i)
         A_STATUS: begin
            rd_val           = MODE_BITS;
            rd_val[BIT_GIE]  = gie_q;
            rd_val[BIT_PGIE] = pgie_q;
         end
         A_ENABLE: begin
            rd_val[BIT_TMR]          = en_tmr_q;
            rd_val[BIT_EXT]          = en_ext_q;
            rd_val[LOC_TOP:LOC_BASE] = en_loc_q;
         end
         A_PEND: begin
            rd_val[BIT_TMR]          = tmr_pend;
            rd_val[BIT_EXT]          = ext_irq_i;
            rd_val[LOC_TOP:LOC_BASE] = lirq_i;
         end
         A_VECTOR: rd_val = vec_q;
         A_RETPC:  rd_val = retpc_full;
         A_CAUSE:  rd_val = cause_q;
         A_CYCLE:  rd_val = cyc_v;
         A_TIMER:  rd_val = tim_v;
         A_TCMP:   rd_val = cmp_v;
         default:  hit = 1'b0;
      endcase
   end

   mtrap_csr_alu #(.W(XW)) alu_i (
      .op_i  (csr_op_i),
      .old_i (rd_val),
      .arg_i (csr_wdata_i),
      .new_o (wr_val)
   );

   assign csr_go = csr_req_i && hit && !exc_valid_i && !mret_i && (csr_op_i != CSR_RD);
   assign wr_cyc = csr_go && (csr_addr_i == A_CYCLE);
   assign wr_tim = csr_go && (csr_addr_i == A_TIMER);
   assign wr_cmp = csr_go && (csr_addr_i == A_TCMP);

   mtrap_counters #(.W(XW), .PRESCALE(TIMER_PRESCALE)) cnt_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_cyc_i   (wr_cyc),
      .wr_time_i  (wr_tim),
      .wr_cmp_i   (wr_cmp),
      .wdata_i    (wr_val),
      .cycle_o    (cyc_v),
      .time_o     (tim_v),
      .cmp_o      (cmp_v),
      .tmr_pend_o (tmr_pend)
   );

   mtrap_irq_pick #(.NLOC(LOCAL_IRQS)) pick_i (
      .glb_en_i   (gie_q),
      .loc_pend_i (lirq_i),
      .loc_en_i   (en_loc_q),
      .tmr_pend_i (tmr_pend),
      .tmr_en_i   (en_tmr_q),
      .ext_pend_i (ext_irq_i),
      .ext_en_i   (en_ext_q),
      .take_o     (irq_take),
      .code_o     (irq_code)
   );

   assign ill_csr    = csr_req_i && !hit && !exc_valid_i;
   assign sync_trap  = exc_valid_i || ill_csr;
   assign irq_go     = irq_take && !sync_trap && !mret_i && !csr_req_i;
   assign trap_go    = sync_trap || irq_go;
   assign ret_go     = mret_i && !sync_trap;
   assign trap_cause = irq_go ? {1'b1, 26'd0, irq_code}
                              : {27'd0, exc_valid_i ? kind_to_cause(exc_kind_i) : 5'd2};
   assign trap_pc    = irq_go ? next_pc_i : cur_pc_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gie_q         <= 1'b0;
         pgie_q        <= 1'b0;
         en_tmr_q      <= 1'b0;
         en_ext_q      <= 1'b0;
         en_loc_q      <= '0;
         vec_q         <= RESET_TVEC;
         retpc_q       <= '0;
         cause_q       <= '0;
         redirect_o    <= 1'b0;
         redirect_pc_o <= '0;
         trap_o        <= 1'b0;
      end else if (trap_go) begin
         retpc_q       <= trap_pc[XW-1:2];
         cause_q       <= trap_cause;
         pgie_q        <= gie_q;
         gie_q         <= 1'b0;
         redirect_o    <= 1'b1;
         redirect_pc_o <= {vec_q[XW-1:2], 2'b00};
         trap_o        <= 1'b1;
      end else if (ret_go) begin
         gie_q         <= pgie_q;
         pgie_q        <= 1'b1;
         redirect_o    <= 1'b1;
         redirect_pc_o <= retpc_full;
         trap_o        <= 1'b0;
      end else begin
         redirect_o <= 1'b0;
         trap_o     <= 1'b0;
         if (csr_go) begin
            case (csr_addr_i)
               A_STATUS: begin
                  gie_q  <= wr_val[BIT_GIE];
                  pgie_q <= wr_val[BIT_PGIE];
               end
               A_ENABLE: begin
                  en_tmr_q <= wr_val[BIT_TMR];
                  en_ext_q <= wr_val[BIT_EXT];
                  en_loc_q <= wr_val[LOC_TOP:LOC_BASE];
               end
               A_VECTOR: vec_q   <= wr_val;
               A_RETPC:  retpc_q <= wr_val[XW-1:2];
               A_CAUSE:  cause_q <= wr_val;
               default:  ;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        csr_rdata_o <= '0;
      else if (csr_req_i) csr_rdata_o <= hit ? rd_val : '0;
   end
endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        trap_o,
   input logic        redirect_o,
   input logic [31:0] redirect_pc_o,
   input logic        gie,
   input logic        pgie,
   input logic [31:0] retpc,
   input logic [31:0] cause,
   input logic [31:0] cycle,
   input logic        cyc_wr
);
   assert_trap_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_o |-> (redirect_o && redirect_pc_o[1:0] == 2'b00 && !gie));

   assert_irq_needs_gie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_o && cause[31]) |-> $past(gie));

   assert_mret_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (redirect_o && !trap_o) |-> (redirect_pc_o == retpc && pgie));

   assert_cycle_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(cyc_wr)) |-> (cycle == $past(cycle) + 32'd1));

   assert_sync_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_o && !cause[31]) |-> (cause < 32'd12));
endmodule

bind mtrap_unit mtrap_unit_chk chk_i (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .trap_o        (trap_o),
   .redirect_o    (redirect_o),
   .redirect_pc_o (redirect_pc_o),
   .gie           (gie_q),
   .pgie          (pgie_q),
   .retpc         (retpc_full),
   .cause         (cause_q),
   .cycle         (cyc_v),
   .cyc_wr        (wr_cyc)
);

// File: tb/mtrap_unit_tb.sv
module mtrap_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] cur_pc = 32'h0000_0900;
   logic [31:0] nxt_pc = 32'h0000_5000;
   logic        exc_v = 1'b0;
   logic [2:0]  exc_k = 3'd0;
   logic        mret = 1'b0;
   logic        ext = 1'b0;
   logic [7:0]  lirq = '0;
   logic        redir;
   logic [31:0] redir_pc;
   logic        trap;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   mtrap_unit dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .csr_req_i (req), .csr_op_i (op), .csr_addr_i (addr),
      .csr_wdata_i (wdata), .csr_rdata_o (rdata),
      .cur_pc_i (cur_pc), .next_pc_i (nxt_pc),
      .exc_valid_i (exc_v), .exc_kind_i (exc_k), .mret_i (mret),
      .ext_irq_i (ext), .lirq_i (lirq),
      .redirect_o (redir), .redirect_pc_o (redir_pc), .trap_o (trap)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] a;
      logic [31:0] w;
      logic [31:0] e;
   } vec_t;

   // op: 0 read, 1 write, 2 set, 3 clear
   localparam vec_t VT [18] = '{
      '{2'd1, 12'h305, 32'h0000_0203, 32'h0000_0000},  // R1 vector write
      '{2'd0, 12'h305, 32'h0000_0000, 32'h0000_0203},  // R1 vector keeps all bits
      '{2'd1, 12'h304, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 enable write
      '{2'd3, 12'h304, 32'h0000_0080, 32'h00FF_0880},  // R4 only defined bits kept
      '{2'd0, 12'h304, 32'h0000_0000, 32'h00FF_0800},  // R1 clear
      '{2'd2, 12'h304, 32'h0000_0080, 32'h00FF_0800},  // R1 set
      '{2'd1, 12'h304, 32'h0000_0000, 32'h00FF_0880},
      '{2'd1, 12'h341, 32'h0000_1237, 32'h0000_0000},  // R1 return PC
      '{2'd0, 12'h341, 32'h0000_0000, 32'h0000_1234},  // R1 low bits zero
      '{2'd1, 12'h342, 32'h8000_0005, 32'h0000_0000},
      '{2'd3, 12'h342, 32'h8000_0000, 32'h8000_0005},
      '{2'd0, 12'h342, 32'h0000_0000, 32'h0000_0005},
      '{2'd1, 12'h344, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 pending not writable
      '{2'd0, 12'h344, 32'h0000_0000, 32'h0000_0000},
      '{2'd1, 12'h300, 32'hFFFF_FFFF, 32'h0000_1800},
      '{2'd0, 12'h300, 32'h0000_0000, 32'h0000_1888},
      '{2'd1, 12'h300, 32'h0000_0000, 32'h0000_1888},
      '{2'd0, 12'h300, 32'h0000_0000, 32'h0000_1800}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic csr(input logic [1:0] o, input logic [11:0] a, input logic [31:0] w,
                      output logic [31:0] r);
      @(negedge clk);
      req = 1'b1; op = o; addr = a; wdata = w;
      @(negedge clk);
      req = 1'b0;
      r = rdata;
   endtask

   task automatic do_mret();
      @(negedge clk);
      mret = 1'b1;
      @(negedge clk);
      mret = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired before all requirements were checked");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r, r2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check("R11 trap_o", {31'd0, trap}, 32'd0);
      check("R11 redirect_o", {31'd0, redir}, 32'd0);
      csr(2'd0, 12'h300, 0, r); check("R11 status", r, 32'h0000_1800);
      csr(2'd0, 12'h305, 0, r); check("R11 vector", r, 32'h0);
      csr(2'd0, 12'h7C1, 0, r); check("R11 compare", r, 32'hFFFF_FFFF);
      csr(2'd0, 12'h342, 0, r); check("R11 cause", r, 32'h0);

      // R1 / R4 table
      for (int i = 0; i < 18; i++) begin
         csr(VT[i].op, VT[i].a, VT[i].w, r);
         check($sformatf("R1/R4 vector %0d", i), r, VT[i].e);
      end

      // R2 cycle counter
      csr(2'd0, 12'hB00, 0, r);
      csr(2'd0, 12'hB00, 0, r2);
      check("R2 cycle step", r2 - r, 32'd2);
      csr(2'd1, 12'hB00, 32'd1000, r);
      csr(2'd0, 12'hB00, 0, r);
      check("R2 cycle after write", r, 32'd1001);

      // R3 timer
      csr(2'd1, 12'h7C1, 32'h0, r);
      csr(2'd0, 12'h344, 0, r); check("R3 pending at compare 0", r, 32'h0000_0080);
      csr(2'd1, 12'h7C1, 32'h1000_0000, r);
      csr(2'd0, 12'h344, 0, r); check("R3 not pending below", r, 32'h0);
      csr(2'd1, 12'h7C0, 32'h0FFF_FFF0, r);
      csr(2'd0, 12'h7C0, 0, r); check("R3 timer after write", r, 32'h0FFF_FFF1);
      repeat (20) @(negedge clk);
      csr(2'd0, 12'h344, 0, r); check("R3 pending after crossing", r, 32'h0000_0080);

      // R8/R5 timer interrupt
      csr(2'd1, 12'h304, 32'h0000_0080, r);
      check("R8 no trap while global enable clear", {31'd0, trap}, 32'd0);
      csr(2'd2, 12'h300, 32'h8, r);
      @(negedge clk);
      check("R8 timer trap taken", {31'd0, trap}, 32'd1);
      check("R5 redirect target", redir_pc, 32'h0000_0200);
      csr(2'd0, 12'h342, 0, r); check("R8 timer cause", r, 32'h8000_0007);
      csr(2'd0, 12'h341, 0, r); check("R5 interrupt return PC", r, 32'h0000_5000);
      csr(2'd0, 12'h300, 0, r); check("R5 status after entry", r, 32'h0000_1880);
      csr(2'd1, 12'h7C1, 32'hFFFF_FFFF, r);

      // R10 mret
      do_mret();
      check("R10 redirect", {31'd0, redir}, 32'd1);
      check("R10 not a trap", {31'd0, trap}, 32'd0);
      check("R10 target", redir_pc, 32'h0000_5000);
      csr(2'd0, 12'h300, 0, r); check("R10 status restored", r, 32'h0000_1888);

      // R8 masked sources are ignored
      lirq = 8'b0010_1000; ext = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R8 masked sources no trap", {31'd0, trap}, 32'd0);
      end

      // R9 priority: local 3 first
      csr(2'd1, 12'h304, 32'h00FF_0880, r);
      @(negedge clk);
      check("R9 local trap taken", {31'd0, trap}, 32'd1);
      csr(2'd0, 12'h342, 0, r); check("R9 lowest local wins", r, 32'h8000_0013);
      csr(2'd0, 12'h344, 0, r); check("R4 pending view", r, 32'h0028_0800);

      // R9 external once locals gone
      @(negedge clk);
      mret = 1'b1; lirq = '0;
      @(negedge clk);
      mret = 1'b0;
      check("R10 redirect before ext", {31'd0, redir}, 32'd1);
      @(negedge clk);
      check("R9 ext trap taken", {31'd0, trap}, 32'd1);
      csr(2'd0, 12'h342, 0, r); check("R9 ext cause", r, 32'h8000_000B);

      // R9 timer beats external
      csr(2'd1, 12'h7C1, 32'h0, r);
      do_mret();
      @(negedge clk);
      check("R9 timer trap taken", {31'd0, trap}, 32'd1);
      csr(2'd0, 12'h342, 0, r); check("R9 timer over ext", r, 32'h8000_0007);

      // R9 exception beats interrupt
      @(negedge clk);
      mret = 1'b1;
      @(negedge clk);
      mret = 1'b0; exc_v = 1'b1; exc_k = 3'd5; cur_pc = 32'h0000_0700;
      @(negedge clk);
      exc_v = 1'b0;
      check("R9 exception trap", {31'd0, trap}, 32'd1);
      csr(2'd0, 12'h342, 0, r); check("R9 exception wins", r, 32'd11);
      csr(2'd0, 12'h341, 0, r); check("R5 exception return PC", r, 32'h0000_0700);
      ext = 1'b0;
      csr(2'd1, 12'h7C1, 32'hFFFF_FFFF, r);
      csr(2'd1, 12'h304, 32'h0, r);

      // R6 cause mapping
      for (int k = 0; k < 6; k++) begin
         logic [31:0] exp_c;
         case (k)
            0: exp_c = 2;  1: exp_c = 0;  2: exp_c = 4;
            3: exp_c = 6;  4: exp_c = 3;  default: exp_c = 11;
         endcase
         @(negedge clk);
         exc_v = 1'b1; exc_k = 3'(k); cur_pc = 32'h0000_1000 + 32'(k * 16);
         @(negedge clk);
         exc_v = 1'b0;
         check($sformatf("R6 trap kind %0d", k), {31'd0, trap}, 32'd1);
         check($sformatf("R5 vector kind %0d", k), redir_pc, 32'h0000_0200);
         csr(2'd0, 12'h342, 0, r); check($sformatf("R6 cause kind %0d", k), r, exp_c);
         csr(2'd0, 12'h341, 0, r);
         check($sformatf("R5 return PC kind %0d", k), r, 32'h0000_1000 + 32'(k * 16));
      end
      csr(2'd0, 12'h300, 0, r); check("R5 status after nested", r, 32'h0000_1800);

      // R7 unknown CSR address
      cur_pc = 32'h0000_0900;
      csr(2'd1, 12'h123, 32'hDEAD_BEEF, r);
      check("R7 read data zero", r, 32'h0);
      check("R7 trap taken", {31'd0, trap}, 32'd1);
      csr(2'd0, 12'h342, 0, r); check("R7 cause", r, 32'd2);
      csr(2'd0, 12'h341, 0, r); check("R7 return PC", r, 32'h0000_0900);

      // R8 global enable clear blocks an enabled pending source
      ext = 1'b1;
      csr(2'd1, 12'h304, 32'h0000_0800, r);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R8 blocked by global enable", {31'd0, trap}, 32'd0);
      end
      ext = 1'b0;

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule